// File: doc/BRIEF.md
# SPI Serial Memory Page-Write Controller

This block is the write side of a serial memory slave on an SPI link in mode 0. It takes chip select, serial clock and serial data already brought into the core clock domain. It shifts in bytes MSB first on rising serial clock edges while chip select is low. A write-enable instruction arms a latch. A following write instruction carries a 16-bit address and any number of data bytes. The data bytes go into a page buffer, and their position inside the page wraps around within that page.

Chip select may rise only right after a complete data byte. When it does, and the rules for acceptance hold, the block starts a self-timed internal cycle and raises write-in-progress for a fixed number of clock cycles. During that cycle it streams every loaded byte to the memory array twice. The first pass erases each byte to all zeros. The second pass programs each byte with its data. A write that breaks any rule is dropped without a trace, except that the write-enable latch is cleared.

The array port is a valid/ready stream. While `mem_valid` is high and `mem_ready` is low, the block keeps address, data and the phase flag unchanged. A transfer happens on each clock edge where both signals are high. The sink may stall for as long as it wants. The internal cycle then stays busy until both passes have completed.

Top module: `spi_page_writer`

## Requirements
- R1: Bytes are sampled MSB first on rising `spi_sclk` while `spi_cs_n` is low. A write frame is opcode 0x02, then the address high byte, then the address low byte, then data bytes.
- R2: A frame that holds exactly one complete byte 0x06 and ends on a byte boundary sets `wel`, provided `wip` is low. A frame with stray bits after that byte leaves `wel` at 0.
- R3: After reset, `wip`, `wel` and `mem_valid` are 0. An accepted write raises `wip` on the first clock edge after `spi_cs_n` rises. `wip` then stays high for exactly TWC_CYCLES cycles unless the array stalls. `wel` is 0 once `wip` falls.
- R4: Each data byte goes to address bits [6:0] = start offset plus its index, modulo 128, within the page given by address bits [15:7]. A later byte that lands on an offset already written replaces the earlier byte.
- R5: A write is dropped (no `wip`, no array transfer) when `wel` is 0 at the end of the frame.
- R6: A write frame that starts while `wip` is high is dropped. It does not disturb the page buffer, and it does not restart the cycle in progress.
- R7: A write is dropped when chip select rises after a partial byte, or before any data byte has arrived.
- R8: A write is dropped when `bp_lvl` locks the address. The encoding of `bp_lvl` is: 00 locks nothing, 01 locks addresses whose bits [15:14] are 11, 10 locks addresses whose bit 15 is 1, and 11 locks everything. No transfer ever targets a locked address.
- R9: A write frame that is dropped clears `wel`.
- R10: The cycle first sends every loaded offset in ascending order with `mem_erase`=1 and `mem_data`=0x00. It then sends the same offsets in ascending order with `mem_erase`=0 and the buffered data. It sends nothing for offsets that were not loaded.
- R11: While `mem_valid`=1 and `mem_ready`=0, the block holds `mem_valid`, `mem_addr`, `mem_data` and `mem_erase` steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock, synchronous to clk |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data in |
| bp_lvl | input | 2 | Block-lock level |
| wel | output | 1 | Write-enable latch |
| wip | output | 1 | Write cycle in progress |
| mem_valid | output | 1 | Array transfer offered |
| mem_ready | input | 1 | Array accepts transfer |
| mem_erase | output | 1 | 1 = erase pass, 0 = program pass |
| mem_addr | output | 16 | Byte address of the transfer |
| mem_data | output | 8 | Byte value of the transfer |

## Verification
The bench sends frames that wrap past the end of the page, including one long enough to overwrite offsets it already filled. A design that incremented the full address, or kept the first value written to an offset, would send the wrong byte to the array. It ends frames after stray bits, or with no data byte, and it lands write frames on every lock level on both sides of the lock boundary. A design that accepted any of these would cause transfers that the scoreboard does not expect. A second write arrives in the middle of a busy cycle, and the array is stalled at random throughout. A controller that restarted its timer, reloaded its buffer or moved its output during a stall would show up as a wrong busy length or as a mismatched item.

// File: rtl/spi_pw_pkg.sv
package spi_pw_pkg;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_WREN  = 8'h06;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ERASE = 2'd1,
    SEQ_PROG  = 2'd2,
    SEQ_HOLD  = 2'd3
  } seq_state_t;

  // lock decision from the lock level and the two top address bits
  function automatic logic page_locked(input logic [1:0] lvl, input logic [1:0] top2);
    case (lvl)
      2'b00:   page_locked = 1'b0;
      2'b01:   page_locked = (top2 == 2'b11);
      2'b10:   page_locked = top2[1];
      default: page_locked = 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/spi_pw_shifter.sv
module spi_pw_shifter #(
  parameter int BYTE_W = 8,
  parameter int HDR_BYTES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              mosi,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_data,
  output logic [2:0]        byte_num,
  output logic              frame_end,
  output logic              frame_aligned,
  output logic [2:0]        frame_bytes
);
  localparam int BIT_W = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);
  localparam logic [2:0] CNT_SAT = 3'(HDR_BYTES + 1);

  logic              sclk_q, cs_q;
  logic [BYTE_W-2:0] sr_q;
  logic [BIT_W-1:0]  bit_q;
  logic [2:0]        cnt_q;
  logic              rise;

  assign rise          = sclk & ~sclk_q & ~cs_n;
  assign frame_end     = cs_n & ~cs_q;
  assign frame_aligned = (bit_q == '0);
  assign frame_bytes   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      sr_q      <= '0;
      bit_q     <= '0;
      cnt_q     <= '0;
      byte_vld  <= 1'b0;
      byte_data <= '0;
      byte_num  <= '0;
    end else begin
      sclk_q   <= sclk;
      cs_q     <= cs_n;
      byte_vld <= 1'b0;
      if (cs_n) begin
        bit_q <= '0;
        cnt_q <= '0;
      end else if (rise) begin
        sr_q  <= {sr_q[BYTE_W-3:0], mosi};
        bit_q <= bit_q + 1'b1;
        if (bit_q == LAST_BIT) begin
          byte_vld  <= 1'b1;
          byte_data <= {sr_q, mosi};
          byte_num  <= cnt_q;
          if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 3'd1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_pw_pagebuf.sv
module spi_pw_pagebuf #(
  parameter int PAGE_BYTES = 128,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          wr_en,
  input  logic [$clog2(PAGE_BYTES)-1:0] wr_idx,
  input  logic [DATA_W-1:0]             wr_data,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          rd_loaded
);
  logic [DATA_W-1:0]     slot_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded_q;

  assign rd_data   = slot_q[rd_idx];
  assign rd_loaded = loaded_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= '0;
    end else if (clr) begin
      loaded_q <= '0;
    end else if (wr_en) begin
      loaded_q[wr_idx] <= 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en && !clr && (wr_idx == g)) slot_q[g] <= wr_data;
      end
    end
  endgenerate
endmodule

// File: rtl/spi_pw_seq.sv
module spi_pw_seq
  import spi_pw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 128,
  parameter int TWC_CYCLES = 1000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 start,
  input  logic [ADDR_W-$clog2(PAGE_BYTES)-1:0] start_page,
  input  logic                                 slot_loaded,
  input  logic [DATA_W-1:0]                    slot_data,
  output logic [$clog2(PAGE_BYTES)-1:0]        rd_idx,
  output logic                                 wip,
  output logic                                 done,
  output logic                                 mem_valid,
  input  logic                                 mem_ready,
  output logic                                 mem_erase,
  output logic [ADDR_W-1:0]                    mem_addr,
  output logic [DATA_W-1:0]                    mem_data
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int PNUM_W = ADDR_W - PAGE_W;
  localparam int TMR_W  = $clog2(TWC_CYCLES + 1);
  localparam logic [TMR_W-1:0]  TMR_END  = TMR_W'(TWC_CYCLES - 1);
  localparam logic [PAGE_W-1:0] LAST_IDX = PAGE_W'(PAGE_BYTES - 1);

  seq_state_t        state_q;
  logic [PAGE_W-1:0] idx_q;
  logic [PNUM_W-1:0] page_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              in_sweep, advance;

  assign in_sweep  = (state_q == SEQ_ERASE) || (state_q == SEQ_PROG);
  assign mem_valid = in_sweep && slot_loaded;
  assign advance   = in_sweep && (!slot_loaded || mem_ready);
  assign mem_erase = (state_q == SEQ_ERASE);
  assign mem_addr  = {page_q, idx_q};
  assign mem_data  = mem_erase ? '0 : slot_data;
  assign rd_idx    = idx_q;
  assign wip       = (state_q != SEQ_IDLE);
  assign done      = (state_q == SEQ_HOLD) && (tmr_q == TMR_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      page_q  <= '0;
      tmr_q   <= '0;
    end else if (state_q == SEQ_IDLE) begin
      if (start) begin
        state_q <= SEQ_ERASE;
        idx_q   <= '0;
        tmr_q   <= '0;
        page_q  <= start_page;
      end
    end else begin
      if (tmr_q != TMR_END) tmr_q <= tmr_q + 1'b1;
      if (done) state_q <= SEQ_IDLE;
      if (advance) begin
        if (idx_q == LAST_IDX) begin
          idx_q   <= '0;
          state_q <= (state_q == SEQ_ERASE) ? SEQ_PROG : SEQ_HOLD;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer
  import spi_pw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 128,
  parameter int TWC_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  input  logic [1:0]        bp_lvl,
  output logic              wel,
  output logic              wip,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_erase,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int PNUM_W = ADDR_W - PAGE_W;
  localparam int HDR_BYTES = 1 + ADDR_W / DATA_W;
  localparam logic [2:0] DATA_NUM = 3'(HDR_BYTES);

  logic              byte_vld, frame_end, frame_aligned;
  logic [DATA_W-1:0] byte_data;
  logic [2:0]        byte_num, frame_bytes;

  spi_pw_shifter #(.BYTE_W(DATA_W), .HDR_BYTES(HDR_BYTES)) u_shift (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
    .byte_vld(byte_vld), .byte_data(byte_data), .byte_num(byte_num),
    .frame_end(frame_end), .frame_aligned(frame_aligned), .frame_bytes(frame_bytes)
  );

  logic [DATA_W-1:0] opcode_q;
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] ptr_q;
  logic              wel_q, frame_busy_q;
  logic              buf_wr, buf_clr, locked, accept, wren_ok, wr_reject, seq_done;
  logic [PAGE_W-1:0] rd_idx;
  logic [DATA_W-1:0] slot_data;
  logic              slot_loaded;

  assign buf_clr = byte_vld && (byte_num == 3'd0) && !wip;
  assign buf_wr  = byte_vld && (byte_num >= DATA_NUM) && (opcode_q == OP_WRITE)
                   && !wip && !frame_busy_q;
  assign locked  = page_locked(bp_lvl, addr_q[ADDR_W-1 -: 2]);

  assign accept    = frame_end && frame_aligned && (frame_bytes > DATA_NUM)
                     && (opcode_q == OP_WRITE) && wel_q && !wip && !frame_busy_q && !locked;
  assign wren_ok   = frame_end && frame_aligned && (frame_bytes == 3'd1)
                     && (opcode_q == OP_WREN) && !wip;
  assign wr_reject = frame_end && (frame_bytes != 3'd0) && (opcode_q == OP_WRITE) && !accept;
  assign wel       = wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opcode_q     <= '0;
      addr_q       <= '0;
      ptr_q        <= '0;
      frame_busy_q <= 1'b0;
      wel_q        <= 1'b0;
    end else begin
      if (byte_vld) begin
        if (byte_num == 3'd0) begin
          opcode_q     <= byte_data;
          frame_busy_q <= wip;
        end else if (byte_num == 3'd1) begin
          addr_q[ADDR_W-1:DATA_W] <= byte_data;
        end else if (byte_num == 3'd2) begin
          addr_q[DATA_W-1:0] <= byte_data;
          ptr_q              <= byte_data[PAGE_W-1:0];
        end else if (buf_wr) begin
          ptr_q <= ptr_q + 1'b1;
        end
      end
      if (wren_ok)                    wel_q <= 1'b1;
      else if (wr_reject || seq_done) wel_q <= 1'b0;
    end
  end

  spi_pw_pagebuf #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr), .wr_idx(ptr_q),
    .wr_data(byte_data), .rd_idx(rd_idx), .rd_data(slot_data), .rd_loaded(slot_loaded)
  );

  spi_pw_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
               .TWC_CYCLES(TWC_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_page(addr_q[ADDR_W-1 -: PNUM_W]),
    .slot_loaded(slot_loaded), .slot_data(slot_data), .rd_idx(rd_idx), .wip(wip),
    .done(seq_done), .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_erase(mem_erase),
    .mem_addr(mem_addr), .mem_data(mem_data)
  );
endmodule

// File: rtl/spi_pw_checker.sv
module spi_pw_checker
  import spi_pw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_BYTES = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        bp_lvl,
  input logic              wel,
  input logic              wip,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_erase,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);

  assert_valid_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> wip);

  assert_erase_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_erase) |-> (mem_data == '0));

  assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)
                                   && $stable(mem_erase)));

  assert_launch_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel));

  assert_end_disarm_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel);

  assert_no_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !page_locked(bp_lvl, mem_addr[ADDR_W-1 -: 2]));

  assert_one_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && $past(mem_valid) && $past(wip))
      |-> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));
endmodule

bind spi_page_writer spi_pw_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                                      .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .bp_lvl(bp_lvl), .wel(wel), .wip(wip),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_erase(mem_erase),
  .mem_addr(mem_addr), .mem_data(mem_data)
);

// File: tb/spi_page_writer_tb.sv
module spi_page_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TWC = 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic spi_sclk = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic [1:0] bp_lvl = 2'b00;
  logic wel, wip, mem_valid, mem_ready = 1'b0, mem_erase;
  logic [15:0] mem_addr;
  logic [7:0] mem_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_page_writer #(.TWC_CYCLES(TWC)) u_dut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .bp_lvl(bp_lvl), .wel(wel), .wip(wip), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_erase(mem_erase), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  typedef struct packed { logic erase; logic [15:0] addr; logic [7:0] data; } item_t;
  item_t exp_q[$];
  int n_checks = 0, n_fail = 0, wip_cycles = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: random back-pressure, pop and compare on each handshake
  always @(negedge clk) begin
    mem_ready = lfsr[0] | lfsr[3];
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (wip) wip_cycles++;
    #1;
    if (rst_n && mem_valid && mem_ready) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected transfer actual=%h expected=none",
                 {mem_erase, mem_addr, mem_data});
      end else begin
        item_t e;
        e = exp_q.pop_front();
        if (e != {mem_erase, mem_addr, mem_data}) begin
          n_fail++;
          $display("FAIL R1 R10 R11 item actual=%h expected=%h",
                   {mem_erase, mem_addr, mem_data}, e);
        end
      end
    end
  end

  function automatic logic [7:0] dbyte(input int k, input logic [7:0] seed);
    return seed + 8'(k * 13);
  endfunction

  task automatic spi_bit(input logic b);
    @(negedge clk); spi_mosi = b; spi_sclk = 1'b0;
    repeat (2) @(negedge clk); spi_sclk = 1'b1;
    repeat (2) @(negedge clk); spi_sclk = 1'b0;
  endtask

  task automatic spi_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) spi_bit(b[i]);
  endtask

  task automatic cs_begin();
    @(negedge clk); spi_cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic cs_finish();
    repeat (3) @(negedge clk); spi_cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wren(input int extra_bits);
    cs_begin(); spi_byte(8'h06);
    for (int i = 0; i < extra_bits; i++) spi_bit(1'b0);
    cs_finish();
  endtask

  task automatic write_frame(input logic [15:0] a, input int n, input logic [7:0] seed,
                             input int extra_bits);
    cs_begin();
    spi_byte(8'h02); spi_byte(a[15:8]); spi_byte(a[7:0]);
    for (int k = 0; k < n; k++) spi_byte(dbyte(k, seed));
    for (int i = 0; i < extra_bits; i++) spi_bit(1'b1);
    cs_finish();
  endtask

  // expected array traffic of an accepted write (R4 wrap model, R10 order)
  task automatic expect_write(input logic [15:0] a, input int n, input logic [7:0] seed);
    logic [7:0] pg [128];
    bit ld [128];
    logic [6:0] off;
    for (int i = 0; i < 128; i++) ld[i] = 1'b0;
    off = a[6:0];
    for (int k = 0; k < n; k++) begin
      pg[off] = dbyte(k, seed); ld[off] = 1'b1; off = off + 7'd1;
    end
    for (int i = 0; i < 128; i++)
      if (ld[i]) exp_q.push_back({1'b1, a[15:7], 7'(i), 8'h00});
    for (int i = 0; i < 128; i++)
      if (ld[i]) exp_q.push_back({1'b0, a[15:7], 7'(i), pg[i]});
  endtask

  task automatic good_write(input string req, input logic [15:0] a, input int n,
                            input logic [7:0] seed);
    wren(0);
    check("R2", "wel after write enable", wel, 1);
    expect_write(a, n, seed);
    wip_cycles = 0;
    write_frame(a, n, seed, 0);
    check(req, "wip after accepted write", wip, 1);
    while (wip) @(negedge clk);
    check("R3", "busy length", wip_cycles, TWC);
    check("R3", "wel after cycle", wel, 0);
    check(req, "items left in scoreboard", exp_q.size(), 0);
  endtask

  task automatic bad_write(input string req, input logic [15:0] a, input int n,
                           input int extra_bits);
    wren(0);
    write_frame(a, n, 8'h5A, extra_bits);
    check(req, "wip after dropped write", wip, 0);
    check("R9", "wel after dropped write", wel, 0);
    repeat (300) @(negedge clk);
    check(req, "wip stays low", wip, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3", "reset wip", wip, 0);
    check("R3", "reset wel", wel, 0);
    check("R3", "reset mem_valid", mem_valid, 0);

    // R5: no write enable
    write_frame(16'h0040, 2, 8'h11, 0);
    check("R5", "wip without enable", wip, 0);
    repeat (300) @(negedge clk);

    // R2: enable frame with stray bits is ignored
    wren(3);
    check("R2", "wel after misaligned enable", wel, 0);

    // R1 R3 R10: single byte
    good_write("R1", 16'h1234, 1, 8'hC3);
    // R4: wrap inside the page
    good_write("R4", 16'h017E, 4, 8'h21);
    // R4: overwrite after a full lap
    good_write("R4", 16'h0205, 130, 8'h07);

    // R6: second write during the busy cycle
    wren(0);
    expect_write(16'h3000, 3, 8'h40);
    wip_cycles = 0;
    write_frame(16'h3000, 3, 8'h40, 0);
    check("R6", "wip after first write", wip, 1);
    write_frame(16'h3100, 2, 8'hF0, 0);
    check("R6", "wip during second write", wip, 1);
    while (wip) @(negedge clk);
    check("R6", "busy length not restarted", wip_cycles, TWC);
    check("R6", "items left in scoreboard", exp_q.size(), 0);
    check("R9", "wel after write dropped while busy", wel, 0);

    // R7: termination rules
    bad_write("R7", 16'h0100, 1, 3);
    bad_write("R7", 16'h0100, 0, 0);

    // R8: lock levels
    bp_lvl = 2'b01;
    bad_write("R8", 16'hC010, 1, 0);
    good_write("R8", 16'h8010, 2, 8'h33);
    bp_lvl = 2'b10;
    bad_write("R8", 16'h8000, 1, 0);
    good_write("R8", 16'h4000, 1, 8'h99);
    bp_lvl = 2'b11;
    bad_write("R8", 16'h0000, 1, 0);
    bp_lvl = 2'b00;
    good_write("R8", 16'hFF80, 2, 8'hE5);

    check("R10", "scoreboard empty at end", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule